// File: doc/BRIEF.md
# DRAM ECC Error Logging Unit

This block sits next to the ECC checker of a DRAM controller. On every checked read it receives the checker's verdict: clean, correctable single-bit, or uncorrectable multi-bit. With the verdict come the DRAM row, the column address and the corrected 64-bit data word. The protected word is 72 bits wide, 64 data bits and 8 check bits. Encoding and decoding happen upstream, so the syndrome result arrives here ready-made.

The block keeps one sticky flag per error class. It records the row of the first failure of each class, and that row holds until software clears the flag by writing 1 to it. Error classes are recorded whether or not signalling is enabled. Each newly logged error can pulse an active-low system-error line, with a separate enable per class.

Every correctable error also raises a scrub request toward the DRAM sequencer. The request carries the corrected word back to the same location, so no software scrub loop is needed. ECC results only mean something after the whole array has been written once, and the surrounding system must make sure of that.

Top module: `ecc_err_logger`

## Requirements
- R1: Out of reset both flags are 0, both captured rows are 0, `serr_n` is 1 and `scrub_valid` is 0.
- R2: A read with `rd_valid`=1 and `rd_status`=2'b01 (correctable) sets `sb_flag` and copies `rd_row` into `sb_row`, visible one clock later, when `sb_flag` was 0.
- R3: A read with `rd_valid`=1 and `rd_status`=2'b10 or 2'b11 (uncorrectable) sets `mb_flag` and copies `rd_row` into `mb_row` one clock later, when `mb_flag` was 0.
- R4: While a class's flag is set, further errors of that class change neither its row nor its flag.
- R5: A cycle with `clr_we`=1 clears `sb_flag` if `clr_bits[0]`=1 and `mb_flag` if `clr_bits[1]`=1; a 0 bit leaves its flag untouched.
- R6: When a clear and an error of the same class fall in the same cycle, the flag reads 0 on the next cycle and the error is logged, with its row, one cycle after that.
- R7: `serr_n` is low for exactly one cycle, in the cycle a flag first reads 1, when the matching `err_cmd` bit was set in the error's cycle (bit 0 for correctable, bit 1 for uncorrectable); otherwise it stays high. Flags are set either way.
- R8: A correctable read with no scrub pending raises `scrub_valid` one clock later, carrying that read's row, column and corrected data. The request and its payload hold until `scrub_ready` is 1 at a clock edge, after which `scrub_valid` drops.
- R9: Correctable reads that arrive while a scrub is pending do not replace its payload and create no further request.
- R10: A read with `rd_valid`=0, or with `rd_status`=2'b00, changes no flag, no row, no scrub request and no `serr_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_valid | input | 1 | A checked read result is present |
| rd_status | input | 2 | 00 clean, 01 correctable, 10/11 uncorrectable |
| rd_row | input | 3 | DRAM row of the read |
| rd_col | input | 10 | Column address of the read |
| rd_fixed_data | input | 64 | Corrected data word |
| err_cmd | input | 2 | Signalling enables: bit 0 correctable, bit 1 uncorrectable |
| clr_we | input | 1 | Flag clear strobe |
| clr_bits | input | 2 | Write-1-to-clear: bit 0 single-bit flag, bit 1 multi-bit flag |
| sb_flag | output | 1 | Sticky correctable-error flag |
| sb_row | output | 3 | Row of the first correctable error |
| mb_flag | output | 1 | Sticky uncorrectable-error flag |
| mb_row | output | 3 | Row of the first uncorrectable error |
| serr_n | output | 1 | Active-low system-error pulse |
| scrub_valid | output | 1 | Scrub write-back request |
| scrub_ready | input | 1 | Sequencer accepts the scrub |
| scrub_row | output | 3 | Row to rewrite |
| scrub_col | output | 10 | Column to rewrite |
| scrub_data | output | 64 | Corrected word to write |

## Verification
A flag or captured row stuck in the wrong state shows on the status ports one clock after the read that should have moved it. A lost first-error lock shows when a second error of the same class overwrites the row. A lost deferred error in the clear collision shows as a flag still at 0 two clocks after the collision. A wrong enable mapping or a stretched pulse shows on `serr_n` in the very cycle the flag first rises. A scrub holder that reloads while pending shows as a changed payload before `scrub_ready` is given.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
    typedef enum logic [1:0] {
        RS_CLEAN  = 2'b00,
        RS_SINGLE = 2'b01,
        RS_MULTI  = 2'b10,
        RS_MULTI2 = 2'b11
    } rd_status_e;

    localparam int unsigned N_CLASS  = 2;
    localparam int unsigned CLS_SB   = 0;
    localparam int unsigned CLS_MB   = 1;
endpackage

// File: rtl/ecc_class_log.sv
module ecc_class_log #(
    parameter int unsigned ROW_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic [ROW_W-1:0] hit_row,
    input  logic             clear,
    output logic             flag,
    output logic [ROW_W-1:0] row,
    output logic             new_log
);
    typedef struct packed {
        logic             flag;
        logic [ROW_W-1:0] row;
        logic             defer;
        logic [ROW_W-1:0] defer_row;
    } log_st_t;

    log_st_t st_d, st_q;
    logic             hit_eff;
    logic [ROW_W-1:0] row_eff;

    always_comb begin
        st_d    = st_q;
        new_log = 1'b0;
        hit_eff = hit | st_q.defer;
        row_eff = st_q.defer ? st_q.defer_row : hit_row;
        st_d.defer = 1'b0;
        if (clear) begin
            // clear takes priority; a colliding error is held for one cycle
            st_d.flag = 1'b0;
            if (hit_eff) begin
                st_d.defer     = 1'b1;
                st_d.defer_row = row_eff;
            end
        end else if (hit_eff && !st_q.flag) begin
            st_d.flag = 1'b1;
            st_d.row  = row_eff;
            new_log   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;
    assign row  = st_q.row;
endmodule

// File: rtl/ecc_scrub_req.sv
module ecc_scrub_req #(
    parameter int unsigned ROW_W  = 3,
    parameter int unsigned COL_W  = 10,
    parameter int unsigned DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic [ROW_W-1:0]  in_row,
    input  logic [COL_W-1:0]  in_col,
    input  logic [DATA_W-1:0] in_data,
    input  logic              ready,
    output logic              valid,
    output logic [ROW_W-1:0]  out_row,
    output logic [COL_W-1:0]  out_col,
    output logic [DATA_W-1:0] out_data
);
    typedef struct packed {
        logic              valid;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [DATA_W-1:0] data;
    } scrub_st_t;

    scrub_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.valid) begin
            if (ready) st_d.valid = 1'b0;
        end else if (hit) begin
            st_d.valid = 1'b1;
            st_d.row   = in_row;
            st_d.col   = in_col;
            st_d.data  = in_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid    = st_q.valid;
    assign out_row  = st_q.row;
    assign out_col  = st_q.col;
    assign out_data = st_q.data;
endmodule

// File: rtl/ecc_err_logger.sv
module ecc_err_logger
    import ecc_log_pkg::*;
#(
    parameter int unsigned ROW_W  = 3,
    parameter int unsigned COL_W  = 10,
    parameter int unsigned DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_valid,
    input  logic [1:0]        rd_status,
    input  logic [ROW_W-1:0]  rd_row,
    input  logic [COL_W-1:0]  rd_col,
    input  logic [DATA_W-1:0] rd_fixed_data,
    input  logic [1:0]        err_cmd,
    input  logic              clr_we,
    input  logic [1:0]        clr_bits,
    output logic              sb_flag,
    output logic [ROW_W-1:0]  sb_row,
    output logic              mb_flag,
    output logic [ROW_W-1:0]  mb_row,
    output logic              serr_n,
    output logic              scrub_valid,
    input  logic              scrub_ready,
    output logic [ROW_W-1:0]  scrub_row,
    output logic [COL_W-1:0]  scrub_col,
    output logic [DATA_W-1:0] scrub_data
);
    typedef struct packed {
        logic serr_n;
    } top_st_t;

    rd_status_e             status;
    logic [N_CLASS-1:0]     cls_hit;
    logic [N_CLASS-1:0]     cls_clear;
    logic [N_CLASS-1:0]     cls_flag;
    logic [N_CLASS-1:0]     cls_new;
    logic [ROW_W-1:0]       cls_row [N_CLASS];
    top_st_t                st_d, st_q;

    assign status            = rd_status_e'(rd_status);
    assign cls_hit[CLS_SB]   = rd_valid && (status == RS_SINGLE);
    assign cls_hit[CLS_MB]   = rd_valid && (status == RS_MULTI || status == RS_MULTI2);
    assign cls_clear         = clr_we ? clr_bits : '0;

    for (genvar k = 0; k < N_CLASS; k++) begin : g_cls
        ecc_class_log #(.ROW_W(ROW_W)) u_log (
            .clk     (clk),
            .rst_n   (rst_n),
            .hit     (cls_hit[k]),
            .hit_row (rd_row),
            .clear   (cls_clear[k]),
            .flag    (cls_flag[k]),
            .row     (cls_row[k]),
            .new_log (cls_new[k])
        );
    end

    ecc_scrub_req #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_scrub (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (cls_hit[CLS_SB]),
        .in_row   (rd_row),
        .in_col   (rd_col),
        .in_data  (rd_fixed_data),
        .ready    (scrub_ready),
        .valid    (scrub_valid),
        .out_row  (scrub_row),
        .out_col  (scrub_col),
        .out_data (scrub_data)
    );

    always_comb begin
        st_d        = st_q;
        st_d.serr_n = ~|(cls_new & err_cmd);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.serr_n <= 1'b1;
        else        st_q        <= st_d;
    end

    assign serr_n  = st_q.serr_n;
    assign sb_flag = cls_flag[CLS_SB];
    assign mb_flag = cls_flag[CLS_MB];
    assign sb_row  = cls_row[CLS_SB];
    assign mb_row  = cls_row[CLS_MB];
endmodule

// File: rtl/ecc_err_logger_chk.sv
module ecc_err_logger_chk #(
    parameter int unsigned ROW_W  = 3,
    parameter int unsigned DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_valid,
    input logic [1:0]        rd_status,
    input logic              clr_we,
    input logic [1:0]        clr_bits,
    input logic              sb_flag,
    input logic [ROW_W-1:0]  sb_row,
    input logic              mb_flag,
    input logic [ROW_W-1:0]  mb_row,
    input logic              serr_n,
    input logic              scrub_valid,
    input logic              scrub_ready,
    input logic [ROW_W-1:0]  scrub_row,
    input logic [DATA_W-1:0] scrub_data
);
    assert_sb_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_status == 2'b01 && !sb_flag && !(clr_we && clr_bits[0])) |=> sb_flag);

    assert_mb_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_status[1] && !mb_flag && !(clr_we && clr_bits[1])) |=> mb_flag);

    assert_sb_row_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sb_flag && !(clr_we && clr_bits[0])) |=> (sb_flag && $stable(sb_row)));

    assert_mb_row_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mb_flag && !(clr_we && clr_bits[1])) |=> (mb_flag && $stable(mb_row)));

    assert_clear_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && clr_bits[0]) |=> !sb_flag);

    assert_serr_on_new_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !serr_n |-> ((sb_flag && !$past(sb_flag)) || (mb_flag && !$past(mb_flag))));

    assert_scrub_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (scrub_valid && !scrub_ready) |=>
            (scrub_valid && $stable(scrub_row) && $stable(scrub_data)));
endmodule

bind ecc_err_logger ecc_err_logger_chk #(.ROW_W(ROW_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_valid    (rd_valid),
    .rd_status   (rd_status),
    .clr_we      (clr_we),
    .clr_bits    (clr_bits),
    .sb_flag     (sb_flag),
    .sb_row      (sb_row),
    .mb_flag     (mb_flag),
    .mb_row      (mb_row),
    .serr_n      (serr_n),
    .scrub_valid (scrub_valid),
    .scrub_ready (scrub_ready),
    .scrub_row   (scrub_row),
    .scrub_data  (scrub_data)
);

// File: tb/ecc_err_logger_bench.sv
module ecc_err_logger_bench;
    localparam int ROW_W  = 3;
    localparam int COL_W  = 10;
    localparam int DATA_W = 64;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              rd_valid;
    logic [1:0]        rd_status;
    logic [ROW_W-1:0]  rd_row;
    logic [COL_W-1:0]  rd_col;
    logic [DATA_W-1:0] rd_fixed_data;
    logic [1:0]        err_cmd;
    logic              clr_we;
    logic [1:0]        clr_bits;
    logic              sb_flag, mb_flag, serr_n, scrub_valid, scrub_ready;
    logic [ROW_W-1:0]  sb_row, mb_row, scrub_row;
    logic [COL_W-1:0]  scrub_col;
    logic [DATA_W-1:0] scrub_data;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    always #5 clk = ~clk;

    ecc_err_logger u_ecc_err_logger (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // drive one read at a negedge; returns after the next negedge
    task automatic rd(input logic [1:0] st, input logic [2:0] row,
                      input logic [9:0] col, input logic [63:0] dat);
        rd_valid = 1'b1; rd_status = st; rd_row = row; rd_col = col; rd_fixed_data = dat;
        @(negedge clk);
        rd_valid = 1'b0; rd_status = 2'b00;
    endtask

    task automatic clr(input logic [1:0] bits);
        clr_we = 1'b1; clr_bits = bits;
        @(negedge clk);
        clr_we = 1'b0; clr_bits = 2'b00;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog act=%h exp=%h", 64'd0, 64'd1);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; rd_valid = 1'b0; rd_status = 2'b00; rd_row = '0; rd_col = '0;
        rd_fixed_data = '0; err_cmd = 2'b00; clr_we = 1'b0; clr_bits = 2'b00;
        scrub_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 sb_flag", 64'(sb_flag), 64'd0);
        chk("R1 mb_flag", 64'(mb_flag), 64'd0);
        chk("R1 rows", 64'({sb_row, mb_row}), 64'd0);
        chk("R1 serr_n", 64'(serr_n), 64'd1);
        chk("R1 scrub_valid", 64'(scrub_valid), 64'd0);

        // R10: invalid or clean reads are ignored
        rd_status = 2'b01; rd_valid = 1'b0; @(negedge clk);
        chk("R10 no valid", 64'({sb_flag, mb_flag, scrub_valid, ~serr_n}), 64'd0);
        rd(2'b00, 3'd6, 10'd7, 64'hDEAD);
        chk("R10 clean", 64'({sb_flag, mb_flag, scrub_valid, ~serr_n}), 64'd0);

        // sweep: enables x rows x error classes
        scrub_ready = 1'b1;
        for (int en = 0; en < 4; en++) begin
            for (int r = 0; r < 8; r++) begin
                for (int st = 1; st < 4; st++) begin
                    logic        is_sb;
                    logic [63:0] dat;
                    logic [9:0]  col;
                    is_sb = (st == 1);
                    dat   = 64'h0123_4567_89AB_CDEF ^ (64'(en * 32 + r * 4 + st) * 64'h0101_0101_0101_0101);
                    col   = 10'(r * 37 + st * 5 + en);
                    err_cmd = 2'(en);
                    clr(2'b11);
                    rd(2'(st), 3'(r), col, dat);
                    if (is_sb) begin
                        chk("R2 sb_flag", 64'(sb_flag), 64'd1);
                        chk("R2 sb_row", 64'(sb_row), 64'(r));
                        chk("R7 serr ce", 64'(serr_n), 64'(!en[0]));
                        chk("R8 scrub", {scrub_valid, scrub_row, scrub_col, 50'd0}, {1'b1, 3'(r), col, 50'd0});
                        chk("R8 scrub data", scrub_data, dat);
                        chk("R7 mb untouched", 64'(mb_flag), 64'd0);
                    end else begin
                        chk("R3 mb_flag", 64'(mb_flag), 64'd1);
                        chk("R3 mb_row", 64'(mb_row), 64'(r));
                        chk("R7 serr ue", 64'(serr_n), 64'(!en[1]));
                        chk("R3 no scrub", 64'(scrub_valid), 64'd0);
                    end
                    // second error of same class, other row
                    rd(2'(st), 3'(r ^ 5), col, ~dat);
                    chk("R4 row kept", 64'(is_sb ? sb_row : mb_row), 64'(r));
                    chk("R7 no serr repeat", 64'(serr_n), 64'd1);
                    @(negedge clk);
                end
            end
        end

        // R5: selective clear
        err_cmd = 2'b00;
        clr(2'b11);
        rd(2'b01, 3'd2, 10'd1, 64'd1);
        rd(2'b10, 3'd4, 10'd1, 64'd1);
        clr(2'b10);
        chk("R5 sb kept", 64'({sb_flag, sb_row}), 64'({1'b1, 3'd2}));
        chk("R5 mb cleared", 64'(mb_flag), 64'd0);
        clr(2'b01);
        chk("R5 sb cleared", 64'(sb_flag), 64'd0);
        clr_we = 1'b1; clr_bits = 2'b00; rd(2'b10, 3'd3, 10'd0, 64'd0); clr_we = 1'b0;
        chk("R5 zero bits", 64'({mb_flag, mb_row}), 64'({1'b1, 3'd3}));

        // R6: clear collides with a new error
        err_cmd = 2'b11;
        rd(2'b01, 3'd1, 10'd2, 64'd2);
        clr_we = 1'b1; clr_bits = 2'b01;
        rd(2'b01, 3'd5, 10'd2, 64'd2);
        clr_we = 1'b0; clr_bits = 2'b00;
        chk("R6 clear first", 64'({sb_flag, serr_n}), 64'({1'b0, 1'b1}));
        @(negedge clk);
        chk("R6 deferred log", 64'({sb_flag, sb_row}), 64'({1'b1, 3'd5}));
        chk("R6 deferred serr", 64'(serr_n), 64'd0);
        @(negedge clk);
        chk("R7 one-cycle pulse", 64'(serr_n), 64'd1);

        // R9: scrub pending blocks reloads
        scrub_ready = 1'b0;
        repeat (2) @(negedge clk);
        rd(2'b01, 3'd2, 10'd100, 64'hAAAA_0000_1111_2222);
        rd(2'b01, 3'd3, 10'd200, 64'h5555_FFFF_EEEE_DDDD);
        chk("R9 payload kept", {scrub_valid, scrub_row, scrub_col, 50'd0}, {1'b1, 3'd2, 10'd100, 50'd0});
        chk("R9 data kept", scrub_data, 64'hAAAA_0000_1111_2222);
        @(negedge clk);
        chk("R8 held w/o ready", 64'(scrub_valid), 64'd1);
        scrub_ready = 1'b1; @(negedge clk); scrub_ready = 1'b0;
        chk("R8 accepted", 64'(scrub_valid), 64'd0);
        @(negedge clk);
        chk("R9 no extra scrub", 64'(scrub_valid), 64'd0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule